// File: doc/BRIEF.md
# Dual-Bank Flash Command Controller

This block places the command interface of a two-bank NOR flash in front of a small on-chip storage array. A host issues writes and reads with a chip select, a write strobe, an output enable, a word address and a data word. Writes build command sequences: unlock prefixes, program, sector erase, whole-array erase, a fast-program mode, erase pause and continue, and a return to reading. Program and erase are paced by parameterized cycle counters. An erase first drives every word of the chosen sectors to zero and then drives them to all ones.

The array is split into a small-sector bank and a large-sector bank. While an operation runs in one bank, reads from the other bank return stored data with the same one-cycle latency as when idle. Reads from the busy bank return a status word. A ready output shows when no timed operation is running. A synchronous reset aborts any work in progress and returns the block to plain reads.

Top module: `dbf_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, any running operation stops, `ready` is 1 after that edge, and later reads return array data. A new command sequence then works normally.
- R2: The four writes (0x55,0xAA), (0xAA,0x55), (0x55,0xA0), (A,D), given as (low 8 address bits, data), store D at word A once the operation completes.
- R3: A read (cs=1, oe=1, we=0) at a clock edge shows its result on `rdata` after that edge. A read of the bank that is not busy returns array data even while an operation runs.
- R4: While a program runs, a read of its bank returns a status word. In that word, bit 7 is the inverse of bit 7 of the data being written, and bit 6 changes value on each successive status read.
- R5: `ready` is 0 while a program or erase runs, and 1 when idle or when an erase is paused.
- R6: When an operation completes, the block returns by itself to reading array data and raises `ready`.
- R7: The writes (0x55,0xAA), (0xAA,0x55), (0x55,0x20) enter fast-program mode. In that mode, (any,0xA0) followed by (A,D) programs a word. The writes (any,0x90), (any,0x00) leave the mode.
- R8: The writes (0x55,0xAA), (0xAA,0x55), (0x55,0x80), (0x55,0xAA), (0xAA,0x55), (S,0x30) select the sector holding S. Each further (S,0x30) within ERASE_WIN idle cycles adds that sector, but only if it lies in the same bank. The erase starts once the window ends. Selected sectors become all ones, other words keep their values, and status bit 7 reads 0 in the busy bank.
- R9: The same five-write prefix followed by (0x55,0x10) erases every word of both banks. During this erase, both banks return status.
- R10: (any,0xB0) during an erase pauses it. In the paused state, reads of unselected sectors return data, reads of selected sectors return status with bit 7 set, and a program may target an unselected sector. (any,0x30) resumes the erase.
- R11: A write that breaks a sequence, or (any,0xF0), returns the decoder to reading and leaves the array unchanged.
- R12: With unit = 2^UNIT_LG words, bank 0 holds sectors of 1,1,1,1,2,2,4,4 units from address 0. Bank 1 follows with fourteen sectors of 8 units each.
- R13: An erase writes zero to every selected word before writing all ones to any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts operations |
| cs | input | 1 | Chip select |
| we | input | 1 | Write strobe, one write per cycle while cs is high |
| oe | input | 1 | Output enable, a read when cs is high and we is low |
| addr | input | 7+UNIT_LG | Word address |
| wdata | input | DW | Write data / command byte |
| rdata | output | DW | Read data or status, valid the cycle after a read |
| ready | output | 1 | 1 when no timed program or erase is running |

## Verification
The bench builds the block with UNIT_LG=1 (256 words), PROG_CYC=12, ERASE_CYC=64 and ERASE_WIN=8. With these values a program stays busy long enough to take two status reads and one read of the other bank inside it. The erase zero-write pass lasts 256 cycles, and it is followed by a 64-cycle hold. This makes it possible to abort with reset inside the hold and see the zeroed words. The small unit size puts the sector edges of R12 at words 2, 8, 12 and 32, where single-word checks can reach them.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  localparam int N_SECT = 22;
  localparam int UNIT_W = 7;

  localparam logic [7:0] A_UNL1 = 8'h55;
  localparam logic [7:0] A_UNL2 = 8'hAA;
  localparam logic [7:0] C_UNL1 = 8'hAA;
  localparam logic [7:0] C_UNL2 = 8'h55;
  localparam logic [7:0] C_PROG = 8'hA0;
  localparam logic [7:0] C_ERS  = 8'h80;
  localparam logic [7:0] C_CHIP = 8'h10;
  localparam logic [7:0] C_SECT = 8'h30;
  localparam logic [7:0] C_SUSP = 8'hB0;
  localparam logic [7:0] C_FAST = 8'h20;
  localparam logic [7:0] C_FX1  = 8'h90;
  localparam logic [7:0] C_FX2  = 8'h00;

  typedef enum logic [1:0] {ST_READ, ST_PROG, ST_ERASE, ST_SUSP} eng_st_t;
  typedef enum logic [1:0] {PH_PRE, PH_HOLD, PH_CLR} ers_ph_t;
  typedef enum logic [3:0] {D_RD, D_U1, D_U2, D_PA, D_E1, D_E2, D_E3, D_EW,
                            D_FM, D_FMPA, D_FMX} dec_st_t;

  function automatic logic [4:0] sect_of_unit(input logic [UNIT_W-1:0] u);
    int v;
    int r;
    v = int'(u);
    if (v < 4)       r = v;
    else if (v < 8)  r = 4 + (v - 4) / 2;
    else if (v < 16) r = 6 + (v - 8) / 4;
    else             r = 8 + (v - 16) / 8;
    return 5'(r);
  endfunction

  function automatic logic bank_of_unit(input logic [UNIT_W-1:0] u);
    return (u[UNIT_W-1:4] != '0);
  endfunction
endpackage

// File: rtl/dbf_array.sv
module dbf_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/dbf_cmd_decode.sv
module dbf_cmd_decode import dbf_pkg::*; #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int ERASE_WIN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  input  eng_st_t           eng_st,
  output logic              go_prog,
  output logic              go_erase,
  output logic              go_susp,
  output logic              go_resume,
  output logic [AW-1:0]     prg_addr,
  output logic [DW-1:0]     prg_data,
  output logic [N_SECT-1:0] ers_mask,
  output logic [1:0]        ers_bm
);
  localparam int WW = $clog2(ERASE_WIN + 1);
  localparam logic [N_SECT-1:0] ONE = {{(N_SECT-1){1'b0}}, 1'b1};

  dec_st_t       ds;
  logic [WW-1:0] win;
  logic [7:0]    a8, cmd;
  logic [4:0]    a_sect;
  logic          a_bank, busy;

  assign a8     = addr[7:0];
  assign cmd    = data[7:0];
  assign a_sect = sect_of_unit(addr[AW-1 -: UNIT_W]);
  assign a_bank = bank_of_unit(addr[AW-1 -: UNIT_W]);
  assign busy   = (eng_st == ST_PROG) || go_prog || go_erase;

  always_ff @(posedge clk) begin
    go_prog   <= 1'b0;
    go_erase  <= 1'b0;
    go_susp   <= 1'b0;
    go_resume <= 1'b0;
    if (rst) begin
      ds       <= D_RD;
      win      <= '0;
      ers_mask <= '0;
      ers_bm   <= '0;
      prg_addr <= '0;
      prg_data <= '0;
    end else if (wr) begin
      if (eng_st == ST_ERASE) begin
        if (cmd == C_SUSP) go_susp <= 1'b1;
      end else if (!busy) begin
        case (ds)
          D_RD: begin
            if (eng_st == ST_SUSP && cmd == C_SECT) go_resume <= 1'b1;
            else if (a8 == A_UNL1 && cmd == C_UNL1) ds <= D_U1;
          end
          D_U1: ds <= (a8 == A_UNL2 && cmd == C_UNL2) ? D_U2 : D_RD;
          D_U2: begin
            if (a8 == A_UNL1 && cmd == C_PROG) ds <= D_PA;
            else if (a8 == A_UNL1 && cmd == C_ERS && eng_st == ST_READ) ds <= D_E1;
            else if (a8 == A_UNL1 && cmd == C_FAST) ds <= D_FM;
            else ds <= D_RD;
          end
          D_PA: begin
            go_prog  <= 1'b1;
            prg_addr <= addr;
            prg_data <= data;
            ds       <= D_RD;
          end
          D_E1: ds <= (a8 == A_UNL1 && cmd == C_UNL1) ? D_E2 : D_RD;
          D_E2: ds <= (a8 == A_UNL2 && cmd == C_UNL2) ? D_E3 : D_RD;
          D_E3: begin
            if (a8 == A_UNL1 && cmd == C_CHIP) begin
              ers_mask <= '1;
              ers_bm   <= 2'b11;
              go_erase <= 1'b1;
              ds       <= D_RD;
            end else if (cmd == C_SECT) begin
              ers_mask <= ONE << a_sect;
              ers_bm   <= a_bank ? 2'b10 : 2'b01;
              win      <= WW'(ERASE_WIN);
              ds       <= D_EW;
            end else ds <= D_RD;
          end
          D_EW: begin
            if (cmd == C_SECT) begin
              if (ers_bm[a_bank]) begin
                ers_mask <= ers_mask | (ONE << a_sect);
                win      <= WW'(ERASE_WIN);
              end
            end else ds <= D_RD;
          end
          D_FM:   ds <= (cmd == C_PROG) ? D_FMPA : ((cmd == C_FX1) ? D_FMX : D_FM);
          D_FMPA: begin
            go_prog  <= 1'b1;
            prg_addr <= addr;
            prg_data <= data;
            ds       <= D_FM;
          end
          D_FMX:  ds <= (cmd == C_FX2) ? D_RD : D_FM;
          default: ds <= D_RD;
        endcase
      end
    end else if (ds == D_EW) begin
      if (win == '0) begin
        go_erase <= 1'b1;
        ds       <= D_RD;
      end else win <= win - 1'b1;
    end
  end

  p_single_go_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_prog, go_erase, go_susp, go_resume}));

  p_erase_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    go_erase |-> (eng_st == ST_READ));
endmodule

// File: rtl/dbf_engine.sv
module dbf_engine import dbf_pkg::*; #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              go_susp,
  input  logic              go_resume,
  input  logic [AW-1:0]     prg_addr,
  input  logic [DW-1:0]     prg_data,
  input  logic [N_SECT-1:0] mask_in,
  input  logic [1:0]        bm_in,
  output eng_st_t           st,
  output logic              ready,
  output logic              ers_on,
  output logic [N_SECT-1:0] ers_mask,
  output logic [1:0]        ers_bm,
  output logic [1:0]        prog_bm,
  output logic              pd_top,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DW-1:0]     ram_wdata
);
  localparam int CMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  ers_ph_t       ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] wa, p_addr;
  logic [DW-1:0] p_data;
  logic          wa_sel, wa_last, prg_hits_sel;

  assign wa_sel       = ers_mask[sect_of_unit(wa[AW-1 -: UNIT_W])];
  assign wa_last      = (wa == '1);
  assign prg_hits_sel = ers_mask[sect_of_unit(prg_addr[AW-1 -: UNIT_W])];
  assign pd_top       = p_data[DW-1];

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = wa;
    ram_wdata = (ph == PH_PRE) ? '0 : '1;
    if (st == ST_PROG) begin
      ram_we    = (cnt == '0);
      ram_waddr = p_addr;
      ram_wdata = p_data;
    end else if (st == ST_ERASE) begin
      ram_we = (ph != PH_HOLD) && wa_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_READ;
      ready    <= 1'b1;
      ers_on   <= 1'b0;
      ers_mask <= '0;
      ers_bm   <= '0;
      prog_bm  <= '0;
      ph       <= PH_PRE;
      cnt      <= '0;
      wa       <= '0;
      p_addr   <= '0;
      p_data   <= '0;
    end else begin
      case (st)
        ST_READ: begin
          if (go_erase) begin
            ers_mask <= mask_in;
            ers_bm   <= bm_in;
            ers_on   <= 1'b1;
            ph       <= PH_PRE;
            wa       <= '0;
            st       <= ST_ERASE;
            ready    <= 1'b0;
          end else if (go_prog) begin
            p_addr  <= prg_addr;
            p_data  <= prg_data;
            prog_bm <= bank_of_unit(prg_addr[AW-1 -: UNIT_W]) ? 2'b10 : 2'b01;
            cnt     <= CW'(PROG_CYC);
            st      <= ST_PROG;
            ready   <= 1'b0;
          end
        end
        ST_PROG: begin
          if (cnt == '0) begin
            st    <= ers_on ? ST_SUSP : ST_READ;
            ready <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_ERASE: begin
          if (go_susp) begin
            st    <= ST_SUSP;
            ready <= 1'b1;
          end else begin
            case (ph)
              PH_PRE: begin
                wa <= wa + 1'b1;
                if (wa_last) begin
                  ph  <= PH_HOLD;
                  cnt <= CW'(ERASE_CYC);
                end
              end
              PH_HOLD: begin
                if (cnt == '0) ph <= PH_CLR;
                else cnt <= cnt - 1'b1;
              end
              default: begin
                wa <= wa + 1'b1;
                if (wa_last) begin
                  st     <= ST_READ;
                  ers_on <= 1'b0;
                  ready  <= 1'b1;
                end
              end
            endcase
          end
        end
        default: begin
          if (go_resume) begin
            st    <= ST_ERASE;
            ready <= 1'b0;
          end else if (go_prog && !prg_hits_sel) begin
            p_addr  <= prg_addr;
            p_data  <= prg_data;
            prog_bm <= bank_of_unit(prg_addr[AW-1 -: UNIT_W]) ? 2'b10 : 2'b01;
            cnt     <= CW'(PROG_CYC);
            st      <= ST_PROG;
            ready   <= 1'b0;
          end
        end
      endcase
    end
  end

  p_busy_after_start_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ && (go_prog || go_erase)) |=> !ready);

  p_susp_prog_safe_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PROG && ers_on) |-> !ers_mask[sect_of_unit(p_addr[AW-1 -: UNIT_W])]);

  p_resume_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SUSP && go_resume) |=> (st == ST_ERASE && !ready));
endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl import dbf_pkg::*; #(
  parameter int UNIT_LG   = 1,
  parameter int DW        = 8,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 64,
  parameter int ERASE_WIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs,
  input  logic                    we,
  input  logic                    oe,
  input  logic [UNIT_W+UNIT_LG-1:0] addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    ready
);
  localparam int AW = UNIT_W + UNIT_LG;

  logic              wr, rd;
  logic              go_prog, go_erase, go_susp, go_resume;
  logic [AW-1:0]     prg_addr;
  logic [DW-1:0]     prg_data;
  logic [N_SECT-1:0] dec_mask, ers_mask;
  logic [1:0]        dec_bm, ers_bm, prog_bm;
  eng_st_t           st;
  logic              ers_on, pd_top;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [DW-1:0]     ram_wdata, ram_q;

  assign wr = cs & we;
  assign rd = cs & oe & ~we;

  dbf_cmd_decode #(.AW(AW), .DW(DW), .ERASE_WIN(ERASE_WIN)) u_dec (
    .clk(clk), .rst(rst), .wr(wr), .addr(addr), .data(wdata), .eng_st(st),
    .go_prog(go_prog), .go_erase(go_erase), .go_susp(go_susp), .go_resume(go_resume),
    .prg_addr(prg_addr), .prg_data(prg_data), .ers_mask(dec_mask), .ers_bm(dec_bm));

  dbf_engine #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_erase(go_erase), .go_susp(go_susp),
    .go_resume(go_resume), .prg_addr(prg_addr), .prg_data(prg_data),
    .mask_in(dec_mask), .bm_in(dec_bm), .st(st), .ready(ready), .ers_on(ers_on),
    .ers_mask(ers_mask), .ers_bm(ers_bm), .prog_bm(prog_bm), .pd_top(pd_top),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata));

  dbf_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(addr), .q(ram_q));

  // read path: status for the busy bank, array data otherwise
  logic          r_bank, hit_prog, hit_ers, hit_sus, tog, sel_q;
  logic [4:0]    r_sect;
  logic [DW-1:0] stat_d, stat_q;

  assign r_bank   = bank_of_unit(addr[AW-1 -: UNIT_W]);
  assign r_sect   = sect_of_unit(addr[AW-1 -: UNIT_W]);
  assign hit_prog = (st == ST_PROG)  && prog_bm[r_bank];
  assign hit_ers  = (st == ST_ERASE) && ers_bm[r_bank];
  assign hit_sus  = (st == ST_SUSP)  && ers_mask[r_sect];

  always_comb begin
    stat_d         = '0;
    stat_d[DW-1]   = hit_prog ? ~pd_top : hit_sus;
    stat_d[DW-2]   = tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog    <= 1'b0;
      sel_q  <= 1'b0;
      stat_q <= '0;
    end else if (rd) begin
      sel_q  <= hit_prog | hit_ers | hit_sus;
      stat_q <= stat_d;
      if (hit_prog | hit_ers) tog <= ~tog;
    end
  end

  assign rdata = sel_q ? stat_q : ram_q;

  p_idle_no_write_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_READ || st == ST_SUSP) |-> !ram_we);

  p_erase_pattern_r13: assert property (@(posedge clk) disable iff (rst)
    (ram_we && st == ST_ERASE) |-> (ram_wdata == '0 || ram_wdata == '1));

  p_erase_in_sel_r8: assert property (@(posedge clk) disable iff (rst)
    (ram_we && st == ST_ERASE) |-> ers_mask[sect_of_unit(ram_waddr[AW-1 -: UNIT_W])]);

  p_erase_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ERASE || st == ST_SUSP) |-> ers_on);
endmodule

// File: tb/dbf_ctrl_test.sv
module dbf_ctrl_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0, we = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ready;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dbf_ctrl #(.UNIT_LG(1), .DW(8), .PROG_CYC(12), .ERASE_CYC(64), .ERASE_WIN(8)) uut (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .oe(oe), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; oe = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [7:0] v);
    cs = 1'b1; oe = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
    cs = 1'b0; oe = 1'b0;
  endtask

  task automatic wait_ready(input string tag, input int lim);
    int n;
    n = 0;
    idle(3);
    while (ready !== 1'b1 && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(tag, {7'b0, ready}, 8'h01);
  endtask

  task automatic prog4(input logic [7:0] a, input logic [7:0] d);
    bwrite(8'h55, 8'hAA); bwrite(8'hAA, 8'h55); bwrite(8'h55, 8'hA0); bwrite(a, d);
  endtask

  task automatic ers_prefix();
    bwrite(8'h55, 8'hAA); bwrite(8'hAA, 8'h55); bwrite(8'h55, 8'h80);
    bwrite(8'h55, 8'hAA); bwrite(8'hAA, 8'h55);
  endtask

  task automatic expect_word(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bread(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    chk("R1 ready after reset", {7'b0, ready}, 8'h01);
  endtask

  task automatic t_chip_erase();
    logic [7:0] v1, v2;
    ers_prefix(); bwrite(8'h55, 8'h10);
    idle(3);
    chk("R5 busy during chip erase", {7'b0, ready}, 8'h00);
    bread(8'd5, v1); bread(8'd5, v2);
    chk("R9 bank0 status toggles", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    chk("R9 erase status bit7 zero", {7'b0, v1[7]}, 8'h00);
    bread(8'd200, v1); bread(8'd200, v2);
    chk("R9 bank1 status toggles", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    wait_ready("R6 ready after chip erase", 2000);
    expect_word("R9 word 0 erased", 8'd0, 8'hFF);
    expect_word("R9 word 31 erased", 8'd31, 8'hFF);
    expect_word("R9 word 32 erased", 8'd32, 8'hFF);
    expect_word("R9 word 255 erased", 8'd255, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v1, v2;
    prog4(8'd40, 8'h3C);
    idle(2);
    chk("R5 busy during program", {7'b0, ready}, 8'h00);
    bread(8'd40, v1); bread(8'd40, v2);
    chk("R4 data polling bit7", {7'b0, v1[7]}, 8'h01);
    chk("R4 toggle bit6", {7'b0, v1[6] ^ v2[6]}, 8'h01);
    bread(8'd5, v1);
    chk("R3 other bank reads array", v1, 8'hFF);
    wait_ready("R6 ready after program", 200);
    expect_word("R2 programmed word", 8'd40, 8'h3C);
  endtask

  task automatic t_fast_mode();
    bwrite(8'h55, 8'hAA); bwrite(8'hAA, 8'h55); bwrite(8'h55, 8'h20);
    bwrite(8'd0, 8'hA0); bwrite(8'd41, 8'h5A);
    wait_ready("R7 fast program done", 200);
    expect_word("R7 fast program word 41", 8'd41, 8'h5A);
    bwrite(8'd7, 8'hA0); bwrite(8'd42, 8'h11);
    wait_ready("R7 second fast program done", 200);
    expect_word("R7 fast program word 42", 8'd42, 8'h11);
    bwrite(8'd0, 8'h90); bwrite(8'd0, 8'h00);
    bwrite(8'd0, 8'hA0); bwrite(8'd43, 8'h77);
    idle(3);
    chk("R7 no program after exit", {7'b0, ready}, 8'h01);
    expect_word("R7 word 43 unchanged after exit", 8'd43, 8'hFF);
  endtask

  task automatic t_bad_seq();
    bwrite(8'h55, 8'hAA); bwrite(8'h55, 8'h55); bwrite(8'h55, 8'hA0); bwrite(8'd44, 8'h00);
    idle(3);
    chk("R11 broken sequence stays ready", {7'b0, ready}, 8'h01);
    expect_word("R11 word 44 unchanged", 8'd44, 8'hFF);
    bwrite(8'h55, 8'hAA); bwrite(8'hAA, 8'h55); bwrite(8'h55, 8'hF0); bwrite(8'd45, 8'h00);
    idle(3);
    expect_word("R11 word 45 unchanged after F0", 8'd45, 8'hFF);
    prog4(8'd46, 8'h81);
    wait_ready("R11 program after reset command", 200);
    expect_word("R11 word 46 programmed", 8'd46, 8'h81);
  endtask

  task automatic t_sector_erase();
    prog4(8'd0, 8'h12);  wait_ready("R2 setup w0", 200);
    prog4(8'd2, 8'h77);  wait_ready("R2 setup w2", 200);
    prog4(8'd11, 8'h5A); wait_ready("R2 setup w11", 200);
    prog4(8'd12, 8'h6B); wait_ready("R2 setup w12", 200);
    ers_prefix();
    bwrite(8'd0, 8'h30); bwrite(8'd8, 8'h30); bwrite(8'd40, 8'h30);
    idle(14);
    chk("R5 busy during sector erase", {7'b0, ready}, 8'h00);
    expect_word("R3 bank1 read during bank0 erase", 8'd40, 8'h3C);
    expect_word("R3 bank1 read during bank0 erase 2", 8'd100, 8'hFF);
    wait_ready("R6 ready after sector erase", 2000);
    expect_word("R8 sector 0 erased", 8'd0, 8'hFF);
    expect_word("R12 sector 4 last word erased", 8'd11, 8'hFF);
    expect_word("R12 sector 1 untouched", 8'd2, 8'h77);
    expect_word("R12 sector 5 untouched", 8'd12, 8'h6B);
    expect_word("R8 other-bank sector not queued", 8'd40, 8'h3C);
  endtask

  task automatic t_suspend();
    logic [7:0] v;
    prog4(8'd16, 8'h44); wait_ready("R2 setup w16", 200);
    ers_prefix(); bwrite(8'd16, 8'h30);
    idle(14);
    chk("R5 busy before suspend", {7'b0, ready}, 8'h00);
    bwrite(8'd0, 8'hB0);
    idle(3);
    chk("R10 ready while paused", {7'b0, ready}, 8'h01);
    expect_word("R10 unselected sector readable", 8'd2, 8'h77);
    bread(8'd16, v);
    chk("R10 selected sector status bit7", {7'b0, v[7]}, 8'h01);
    prog4(8'd3, 8'h66);
    idle(2);
    chk("R10 program while paused busy", {7'b0, ready}, 8'h00);
    wait_ready("R10 program while paused done", 200);
    expect_word("R10 word programmed while paused", 8'd3, 8'h66);
    bwrite(8'd0, 8'h30);
    idle(3);
    chk("R10 busy after resume", {7'b0, ready}, 8'h00);
    wait_ready("R6 ready after resumed erase", 2000);
    expect_word("R10 resumed erase finished", 8'd16, 8'hFF);
    expect_word("R10 paused program kept", 8'd3, 8'h66);
  endtask

  task automatic t_hw_reset();
    ers_prefix(); bwrite(8'd0, 8'h30);
    idle(290);
    chk("R5 busy before abort", {7'b0, ready}, 8'h00);
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    chk("R1 ready after abort", {7'b0, ready}, 8'h01);
    expect_word("R13 word 0 preprogrammed to zero", 8'd0, 8'h00);
    expect_word("R13 word 1 preprogrammed to zero", 8'd1, 8'h00);
    expect_word("R1 unselected word kept", 8'd2, 8'h77);
    prog4(8'd50, 8'h99);
    wait_ready("R1 program after abort", 200);
    expect_word("R1 word 50 programmed", 8'd50, 8'h99);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_chip_erase();
    t_program();
    t_fast_mode();
    t_bad_seq();
    t_sector_erase();
    t_suspend();
    t_hw_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule